// File: doc/BRIEF.md
# Converter Host Bus Interface

This block connects a host processor's parallel bus to a sampling converter. The host drives an active-low chip select, separate active-low read and write strobes, and one address line. With the address line low, a read takes the next sample from an internal result FIFO. With the address line high, a read returns a status word and a write loads control settings. The converter side pushes finished 12-bit results into the FIFO. A data-ready output tells the host when the FIFO holds enough words.

Writes are qualified against the converter clock. The internal register-write enable exists only while a write strobe overlaps a low phase of that clock, and the write commits at the rising edge that ends that low phase.

A host access can land while a conversion-start pulse is active. In that case the block raises a wait request and holds the access until the start pulse has ended and the converter reports it is no longer busy. Every access also sends a one-clock pulse to the conversion sequencer so that it can stall.

Top module: `conv_host_if`

## Requirements
- R1: When chip select and the read strobe are both low with the address line low, the block returns FIFO words in arrival order. The output-enable flag rises one clock after the strobes assert, and the data is valid while it is high.
- R2: A read with the address line high returns the status word. Its bit fields are:
  - bit 0: FIFO empty
  - bit 1: FIFO full
  - bit 2: converter busy (busy_n low)
  - bit 3: overflow
  - bit 4: underflow
  - bits 7:5: zero
  - bits 11:8: data-ready threshold
- R3: A write with chip select and the write strobe low and the address line high loads din[11:8] as the threshold. A write with the address line low changes nothing that the status word shows.
- R4: The register-write enable is high only while a qualifying write strobe is asserted and the clock is low.
- R5: The FIFO holds 8 words. A push into a full FIFO discards the word and sets the overflow flag. The first 8 words can still be read in order.
- R6: A FIFO read while the FIFO is empty returns the most recent word read from the FIFO and sets the underflow flag.
- R7: A status read reports the overflow and underflow flags and then clears them.
- R8: Data-ready is high while the FIFO word count is at least the threshold. The threshold is 1 after reset.
- R9: Each assertion of a read or write strobe gives exactly one clock-wide access pulse, one clock after the strobes assert.
- R10: An access that begins while the start input is low raises the wait request. The wait stays high until the start input is high and busy_n is high. Only then does the access complete, and a FIFO read pops exactly one word.
- R11: After reset:
  - the FIFO is empty with no flags set;
  - the threshold is 1;
  - wait request, output enable, access pulse and data-ready are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 1 | 0 selects the FIFO, 1 selects status/control |
| din | input | 12 | Host write data |
| dout | output | 12 | Host read data |
| dout_oe | output | 1 | High while dout should drive the bus |
| reg_wr_en | output | 1 | Internal register-write enable (strobe overlapping clock low) |
| wait_req | output | 1 | Wait request to stall the host |
| acc_pulse | output | 1 | One-clock access pulse to the sequencer stall input |
| convst_n | input | 1 | Conversion-start pulse, active low |
| busy_n | input | 1 | Converter busy, active low |
| res_we | input | 1 | Converter result push |
| res_data | input | 12 | Converter result word |
| drdy | output | 1 | Data-ready, FIFO count at or above threshold |

## Verification
The hardest case to reach is an extended read whose release is split in two steps. The start input rises first while busy_n is still low, and the wait request must stay high through that gap. Only the later rise of busy_n may let the read finish. The bench holds a FIFO read open and drives convst_n and busy_n by hand. It checks the wait request and the output enable at each step. A final status read then shows that exactly one word left the FIFO.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
   localparam int STAT_EMPTY = 0;
   localparam int STAT_FULL  = 1;
   localparam int STAT_BUSY  = 2;
   localparam int STAT_OVF   = 3;
   localparam int STAT_UNF   = 4;
   localparam int STAT_FLAGS = 5;

   typedef enum logic {
      SEL_FIFO = 1'b0,
      SEL_CSR  = 1'b1
   } hbi_sel_e;
endpackage

// File: rtl/hbi_fifo.sv
module hbi_fifo #(
   parameter int DW    = 12,
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full,
   output logic          ovf_evt
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("hbi_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [DEPTH-1:0][DW-1:0] mem;
   logic [AW-1:0]            wp_q, rp_q;
   logic [CW-1:0]            cnt_q;
   logic                     do_push, do_pop;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CW'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign ovf_evt = push && full && !do_pop;
   assign head    = mem[rp_q];
   assign count   = cnt_q;

   always_ff @(posedge clk) begin
      if (do_push) mem[wp_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + AW'(1);
         if (do_pop)  rp_q <= rp_q + AW'(1);
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));                                           // R5
   AST_FIFO_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> full);                               // R5
endmodule

// File: rtl/hbi_strobe_dec.sv
module hbi_strobe_dec #(
   parameter bit WR_OVERLAP = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic rd_n,
   input  logic wr_n,
   input  logic addr,
   output logic rd_act,
   output logic wr_act,
   output logic wr_ok,
   output logic acc_now,
   output logic acc_pulse,
   output logic reg_wr_en
);
   logic wr_any;
   logic acc_prev_q, pulse_q;

   assign rd_act  = !cs_n && !rd_n;
   assign wr_any  = !cs_n && !wr_n;
   assign wr_act  = wr_any && addr;
   assign acc_now = rd_act || wr_any;

   if (WR_OVERLAP) begin : g_overlap
      logic lo_seen_q;
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) lo_seen_q <= 1'b0;
         else        lo_seen_q <= wr_act;
      end
      assign reg_wr_en = wr_act && !clk;
      assign wr_ok     = wr_act && lo_seen_q;
   end else begin : g_level
      assign reg_wr_en = wr_act;
      assign wr_ok     = wr_act;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_prev_q <= 1'b0;
         pulse_q    <= 1'b0;
      end else begin
         acc_prev_q <= acc_now;
         pulse_q    <= acc_now && !acc_prev_q;
      end
   end
   assign acc_pulse = pulse_q;

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_pulse |=> !acc_pulse);                                      // R9
endmodule

// File: rtl/hbi_wait_ctl.sv
module hbi_wait_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic acc_now,
   input  logic convst_n,
   input  logic busy_n,
   output logic wait_o
);
   logic ext_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ext_q <= 1'b0;
      else if (!acc_now)  ext_q <= 1'b0;
      else if (!convst_n) ext_q <= 1'b1;
   end

   assign wait_o = acc_now && (ext_q || !convst_n) && !(convst_n && busy_n);

   AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_o && acc_now) |=> (wait_o || !acc_now || (convst_n && busy_n))); // R10
endmodule

// File: rtl/conv_host_if.sv
module conv_host_if #(
   parameter int DW         = 12,
   parameter int DEPTH      = 8,
   parameter bit WR_OVERLAP = 1'b1,
   localparam int CW        = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic          addr,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout,
   output logic          dout_oe,
   output logic          reg_wr_en,
   output logic          wait_req,
   output logic          acc_pulse,
   input  logic          convst_n,
   input  logic          busy_n,
   input  logic          res_we,
   input  logic [DW-1:0] res_data,
   output logic          drdy
);
   import hbi_pkg::*;

   if (DW < STAT_FLAGS + CW) begin : g_bad_width
      $error("conv_host_if: DW too small for status layout");
   end

   hbi_sel_e      sel;
   logic          rd_act, wr_act, wr_ok, acc_now, wait_o;
   logic          rd_done_q, wr_done_q, rd_go, wr_go, pop;
   logic          empty, full, ovf_evt;
   logic [DW-1:0] head, rd_q, last_q, stat;
   logic [CW-1:0] count, thr_q;
   logic          ovf_q, unf_q;
   logic          unused_din;

   assign sel        = hbi_sel_e'(addr);
   assign unused_din = ^din[DW-CW-1:0];

   hbi_strobe_dec #(.WR_OVERLAP(WR_OVERLAP)) u_dec (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .rd_act(rd_act), .wr_act(wr_act), .wr_ok(wr_ok),
      .acc_now(acc_now), .acc_pulse(acc_pulse), .reg_wr_en(reg_wr_en)
   );

   hbi_wait_ctl u_wait (
      .clk(clk), .rst_n(rst_n), .acc_now(acc_now),
      .convst_n(convst_n), .busy_n(busy_n), .wait_o(wait_o)
   );

   hbi_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(res_we), .wdata(res_data),
      .pop(pop), .head(head), .count(count), .empty(empty),
      .full(full), .ovf_evt(ovf_evt)
   );

   assign rd_go = rd_act && !wait_o && !rd_done_q;
   assign wr_go = wr_ok && !wait_o && !wr_done_q;
   assign pop   = rd_go && (sel == SEL_FIFO) && !empty;

   always_comb begin
      stat             = '0;
      stat[STAT_EMPTY] = empty;
      stat[STAT_FULL]  = full;
      stat[STAT_BUSY]  = !busy_n;
      stat[STAT_OVF]   = ovf_q;
      stat[STAT_UNF]   = unf_q;
      stat[DW-1 -: CW] = thr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_done_q <= 1'b0;
         wr_done_q <= 1'b0;
         rd_q      <= '0;
         last_q    <= '0;
         thr_q     <= CW'(1);
         ovf_q     <= 1'b0;
         unf_q     <= 1'b0;
      end else begin
         rd_done_q <= rd_act && (rd_done_q || rd_go);
         wr_done_q <= wr_act && (wr_done_q || wr_go);
         if (rd_go) begin
            if (sel == SEL_CSR) begin
               rd_q <= stat;
            end else if (!empty) begin
               rd_q   <= head;
               last_q <= head;
            end else begin
               rd_q <= last_q;
            end
         end
         if (ovf_evt)                      ovf_q <= 1'b1;
         else if (rd_go && sel == SEL_CSR) ovf_q <= 1'b0;
         if (rd_go && sel == SEL_FIFO && empty) unf_q <= 1'b1;
         else if (rd_go && sel == SEL_CSR)      unf_q <= 1'b0;
         if (wr_go) thr_q <= din[DW-1 -: CW];
      end
   end

   assign dout     = rd_q;
   assign dout_oe  = rd_act && rd_done_q;
   assign wait_req = wait_o;
   assign drdy     = (count >= thr_q);

   AST_THR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(thr_q) |-> $past(wr_act));                             // R3
   AST_UNF_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unf_q) |-> $past(empty));                                 // R6
   AST_NO_POP_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_oe) |-> $past(!wait_o));                             // R10
endmodule

// File: tb/tb_conv_host_if.sv
module tb_conv_host_if;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, addr = 1'b0;
   logic [11:0] din = '0, res_data = '0;
   logic        convst_n = 1'b1, busy_n = 1'b1, res_we = 1'b0;
   logic [11:0] dout;
   logic        dout_oe, reg_wr_en, wait_req, acc_pulse, drdy;

   int checks = 0;
   int errors = 0;
   bit ended  = 1'b0;

   conv_host_if dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
      .reg_wr_en(reg_wr_en), .wait_req(wait_req), .acc_pulse(acc_pulse),
      .convst_n(convst_n), .busy_n(busy_n), .res_we(res_we),
      .res_data(res_data), .drdy(drdy)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic push(input logic [11:0] v);
      @(posedge clk); #2;
      res_we = 1'b1; res_data = v;
      @(posedge clk); #2;
      res_we = 1'b0;
   endtask

   task automatic host_read(input logic a, output logic [11:0] d);
      int n = 0;
      @(posedge clk); #2;
      cs_n = 1'b0; rd_n = 1'b0; addr = a;
      do begin
         @(posedge clk); #2;
         n++;
      end while (!dout_oe && n < 50);
      chk(dout_oe, "R1 read completion", int'(dout_oe), 1);
      d = dout;
      cs_n = 1'b1; rd_n = 1'b1;
   endtask

   task automatic host_write(input logic a, input logic [11:0] v);
      @(posedge clk); #2;
      cs_n = 1'b0; wr_n = 1'b0; addr = a; din = v;
      #1;
      chk(reg_wr_en == 1'b0, "R4 enable low in clock high", int'(reg_wr_en), 0);
      @(negedge clk); #1;
      chk(reg_wr_en == a, "R4 enable in clock low", int'(reg_wr_en), int'(a));
      @(posedge clk); #2;
      chk(reg_wr_en == 1'b0, "R4 enable after edge", int'(reg_wr_en), 0);
      cs_n = 1'b1; wr_n = 1'b1;
   endtask

   task automatic t_reset();
      logic [11:0] d;
      chk(!dout_oe && !wait_req && !acc_pulse, "R11 outputs idle",
          int'({dout_oe, wait_req, acc_pulse}), 0);
      chk(drdy == 1'b0, "R11 drdy low", int'(drdy), 0);
      host_read(1'b1, d);
      chk(d == 12'h101, "R11 R2 status after reset", int'(d), 'h101);
   endtask

   task automatic t_threshold();
      logic [11:0] d;
      host_write(1'b1, 12'h400);
      host_read(1'b1, d);
      chk(d == 12'h401, "R3 threshold write", int'(d), 'h401);
      host_write(1'b0, 12'hF00);
      host_read(1'b1, d);
      chk(d == 12'h401, "R3 addr low write ignored", int'(d), 'h401);
      push(12'h111); push(12'h222); push(12'h333);
      chk(drdy == 1'b0, "R8 below threshold", int'(drdy), 0);
      push(12'h444);
      chk(drdy == 1'b1, "R8 at threshold", int'(drdy), 1);
      for (int i = 1; i <= 4; i++) begin
         host_read(1'b0, d);
         chk(d == 12'(i * 'h111), "R1 fifo order", int'(d), i * 'h111);
      end
   endtask

   task automatic t_underflow();
      logic [11:0] d;
      host_read(1'b0, d);
      chk(d == 12'h444, "R6 empty read returns last", int'(d), 'h444);
      host_read(1'b1, d);
      chk(d == 12'h411, "R6 underflow flag", int'(d), 'h411);
      host_read(1'b1, d);
      chk(d == 12'h401, "R7 underflow cleared", int'(d), 'h401);
      host_write(1'b1, 12'h100);
   endtask

   task automatic t_overflow();
      logic [11:0] d;
      for (int i = 0; i < 9; i++) push(12'hA00 + 12'(i));
      host_read(1'b1, d);
      chk(d == 12'h10A, "R5 full and overflow", int'(d), 'h10A);
      host_read(1'b1, d);
      chk(d == 12'h102, "R7 overflow cleared", int'(d), 'h102);
      for (int i = 0; i < 8; i++) begin
         host_read(1'b0, d);
         chk(d == 12'hA00 + 12'(i), "R5 kept words", int'(d), 'hA00 + i);
      end
      host_read(1'b1, d);
      chk(d == 12'h101, "R5 drained", int'(d), 'h101);
   endtask

   task automatic t_pulse();
      push(12'h0C3);
      @(posedge clk); #2;
      cs_n = 1'b0; rd_n = 1'b0; addr = 1'b0;
      @(posedge clk); #2;
      chk(acc_pulse == 1'b1, "R9 pulse high", int'(acc_pulse), 1);
      chk(dout_oe && dout == 12'h0C3, "R1 data with oe", int'(dout), 'h0C3);
      @(posedge clk); #2;
      chk(acc_pulse == 1'b0, "R9 pulse one clock", int'(acc_pulse), 0);
      cs_n = 1'b1; rd_n = 1'b1;
      @(posedge clk); #2;
      chk(acc_pulse == 1'b0, "R9 no pulse on release", int'(acc_pulse), 0);
   endtask

   task automatic t_wait();
      logic [11:0] d;
      push(12'h5A5);
      @(posedge clk); #2;
      convst_n = 1'b0; busy_n = 1'b0;
      cs_n = 1'b0; rd_n = 1'b0; addr = 1'b0;
      #1;
      chk(wait_req == 1'b1, "R10 wait raised", int'(wait_req), 1);
      repeat (2) @(posedge clk);
      #2;
      chk(!dout_oe && wait_req, "R10 held during start",
          int'({dout_oe, wait_req}), 1);
      convst_n = 1'b1;
      @(posedge clk); #2;
      chk(!dout_oe && wait_req, "R10 held while busy",
          int'({dout_oe, wait_req}), 1);
      busy_n = 1'b1;
      #1;
      chk(wait_req == 1'b0, "R10 wait released", int'(wait_req), 0);
      @(posedge clk); #2;
      chk(dout_oe && dout == 12'h5A5, "R10 access completes",
          int'(dout), 'h5A5);
      cs_n = 1'b1; rd_n = 1'b1;
      host_read(1'b1, d);
      chk(d == 12'h101, "R10 single pop", int'(d), 'h101);
      busy_n = 1'b0;
      host_read(1'b1, d);
      chk(d == 12'h105, "R2 busy bit", int'(d), 'h105);
      busy_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog act=timeout exp=done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(posedge clk); #2;
      t_reset();
      t_threshold();
      t_underflow();
      t_overflow();
      t_pulse();
      t_wait();
      repeat (2) @(posedge clk);
      finish_run();
   end
endmodule